// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block sits at the front of a small DMA controller. It decides which of four channels owns the transfer bus, and when. Each channel has a control word with four fields: an enable bit, a terminal-count bit, a software trigger bit and a block-mode bit. Each channel also has a selector that picks one of several peripheral interrupt lines as its hardware trigger. A rising edge on the selected line is caught and held per channel, so a pulse that arrives while another channel owns the bus is not lost. The datapath behind the block moves one byte, half-word or word for each `xfer_start` strobe. It answers with `xfer_done`, and raises `xfer_last` with it on the final unit of the channel's count.

Arbitration uses fixed priority: the lowest channel index wins. In single-step mode the owner releases the bus after every unit, and the arbiter chooses again. In block mode the owner keeps the bus until its last unit. A rising edge on the non-maskable interrupt input stops the controller, but the unit already in flight finishes first. At the end of that unit, or at once if the bus is idle, every enable bit is cleared and `nmi_ack` pulses. A block that was interrupted stays latched. Setting its enable bit again resumes the block. A single-step channel instead discards whatever it had pending.

Top module: `dma_req_arbiter`

## Requirements
- R1: When several channels are eligible at an arbitration point, the grant goes to the lowest-indexed one. Channel 0 is highest.
- R2: In single-step mode, `bus_req` and `grant` go low for exactly the one cycle after a unit's `xfer_done`. In the following cycle the highest-priority pending channel is granted, even if it is not the previous owner.
- R3: In block mode, `grant` and `bus_req` stay unchanged across units, and `xfer_start` pulses in the cycle after each non-final `xfer_done`. No other channel can take the bus until the unit flagged `xfer_last` completes.
- R4: A hardware request is recorded only on a rising edge of the peripheral line picked by the channel's selector. It is recorded only while enable is 1 and terminal count is 0. A line held high gives one request, and edges on other lines have no effect.
- R5: A software request starts a channel when trigger, enable and terminal count read 1, 1 and 0. The trigger bit reads 0 once the channel has been granted.
- R6: The channel's terminal-count bit reads 1 after the unit flagged `xfer_last`. A channel whose terminal-count bit is 1 is never granted.
- R7: An NMI edge during a unit does not cut that unit short. `nmi_ack` stays low until the unit's `xfer_done`, pulses in that cycle, and then every enable bit reads 0. An NMI edge while the bus is idle is acknowledged in the same cycle.
- R8: After an NMI stops a block-mode channel mid-block, writing its enable bit back to 1 regrants it in the next cycle with no new trigger. The block then continues until its `xfer_last` unit.
- R9: After an NMI, a single-step channel that is enabled again ignores any request latched before the NMI, and waits for a new trigger.
- R10: `grant` is one-hot or zero, and it is nonzero exactly when `bus_req` is high.
- R11: After reset, all enable, terminal-count and trigger bits read 0, and `grant`, `bus_req`, `xfer_start` and `nmi_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | NUM_CH | Per-channel write strobe for the control word |
| cfg_en | input | 1 | Enable value to write |
| cfg_tc | input | 1 | Terminal-count value to write |
| cfg_stg | input | 1 | Software trigger value to write |
| cfg_blk | input | 1 | 1 = block mode, 0 = single-step mode |
| cfg_sel | input | SEL_W | Index of the peripheral line used as hardware trigger |
| periph_irq | input | NUM_SRC | Peripheral interrupt lines |
| nmi_in | input | 1 | Non-maskable interrupt, rising-edge sensitive |
| xfer_done | input | 1 | Datapath: current unit finished |
| xfer_last | input | 1 | With `xfer_done`: that unit was the last of the count |
| grant | output | NUM_CH | One-hot owner of the bus |
| bus_req | output | 1 | Bus requested on behalf of the owner |
| xfer_start | output | 1 | One-cycle strobe to start a unit |
| nmi_ack | output | 1 | Pulse: NMI taken, enables cleared |
| ch_en | output | NUM_CH | Enable bits read back |
| ch_tc | output | NUM_CH | Terminal-count bits read back |
| ch_stg | output | NUM_CH | Software trigger bits read back |

## Verification
The bench drives a higher-priority peripheral edge during another channel's single-step unit. A design that switched owners mid-unit, or that lost the edge, would show the wrong grant in the cycle after the bus release. Block mode is tested with a higher-priority channel triggered mid-block. An arbiter that re-arbitrated at unit boundaries would hand the bus away before the last unit. NMI is raised mid-unit in both modes: an early `nmi_ack` exposes a design that cuts the unit short, a block channel that needs a fresh trigger after re-enable shows a lost hold, and a single-step channel that restarts with no new edge shows a stale request kept across the abort.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int DMA_NUM_CH  = 4;
    localparam int DMA_NUM_SRC = 8;

    // Sequencer state: either waiting at an arbitration point or owning the bus.
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } seq_state_e;

    // Per-channel control word fields.
    typedef struct packed {
        logic en;   // channel enabled
        logic tc;   // terminal count reached
        logic stg;  // software trigger
        logic blk;  // block mode (1) or single-step (0)
    } ch_ctrl_t;

    // Isolate the lowest set bit: that is the highest-priority requester.
    function automatic logic [DMA_NUM_CH-1:0] lowest_set(input logic [DMA_NUM_CH-1:0] v);
        return v & (~v + DMA_NUM_CH'(1));
    endfunction

endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] req,
    output logic [NUM_CH-1:0] pick
);
    // Fixed priority: lowest index wins.
    always_comb begin
        pick = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_ch_ctrl.sv
module dma_ch_ctrl
    import dma_arb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int SEL_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  ch_ctrl_t           wdata,
    input  logic [SEL_W-1:0]   wsel,
    input  logic [NUM_SRC-1:0] src_rise,
    input  logic               accept,
    input  logic               last_done,
    input  logic               nmi_clr,
    output ch_ctrl_t           ctrl,
    output logic               req
);
    ch_ctrl_t         ctrl_q;
    logic [SEL_W-1:0] sel_q;
    logic             hw_pend;
    logic             hold;
    logic             hw_edge;
    logic             hw_pend_nxt;

    // A selected edge counts only while the channel may start.
    assign hw_edge = ctrl_q.en & ~ctrl_q.tc & src_rise[sel_q];

    always_comb begin
        if (nmi_clr || (wr && !wdata.en) || !ctrl_q.en) begin
            hw_pend_nxt = 1'b0;
        end else begin
            hw_pend_nxt = (hw_pend & ~accept) | hw_edge;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            sel_q   <= '0;
            hw_pend <= 1'b0;
            hold    <= 1'b0;
        end else begin
            if (nmi_clr)      ctrl_q.en <= 1'b0;
            else if (wr)      ctrl_q.en <= wdata.en;

            if (wr)             ctrl_q.tc <= wdata.tc;
            else if (last_done) ctrl_q.tc <= 1'b1;

            if (nmi_clr)     ctrl_q.stg <= 1'b0;
            else if (wr)     ctrl_q.stg <= wdata.stg;
            else if (accept) ctrl_q.stg <= 1'b0;

            if (wr) begin
                ctrl_q.blk <= wdata.blk;
                sel_q      <= wsel;
            end

            hw_pend <= hw_pend_nxt;

            // A granted block stays owed until its final unit, surviving NMI.
            if (last_done)                hold <= 1'b0;
            else if (accept && ctrl_q.blk) hold <= 1'b1;
        end
    end

    assign ctrl = ctrl_q;
    assign req  = ctrl_q.en & ~ctrl_q.tc & (hw_pend | ctrl_q.stg | hold);

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] req,
    input  logic [NUM_CH-1:0] blk_mode,
    input  logic              xfer_done,
    input  logic              xfer_last,
    input  logic              nmi_in,
    output logic [NUM_CH-1:0] grant,
    output logic              bus_req,
    output logic              xfer_start,
    output logic [NUM_CH-1:0] accept,
    output logic [NUM_CH-1:0] last_done,
    output logic              nmi_clr,
    output logic              owner_blk,
    output logic              nmi_hit
);
    seq_state_e        state;
    logic [NUM_CH-1:0] owner;
    logic [NUM_CH-1:0] pick;
    logic              start_q;
    logic              nmi_q;
    logic              nmi_pend;
    logic              unit_end;
    logic              nmi_rise;

    dma_prio_pick #(.NUM_CH(NUM_CH)) u_pick (
        .req  (req),
        .pick (pick)
    );

    assign nmi_rise  = nmi_in & ~nmi_q;
    assign nmi_hit   = nmi_pend | nmi_rise;
    assign unit_end  = (state == ST_XFER) & xfer_done;
    assign owner_blk = |(owner & blk_mode);

    // NMI is serviced only where no unit is in flight.
    assign nmi_clr   = nmi_hit & ((state == ST_IDLE) | unit_end);
    assign accept    = (state == ST_IDLE && !nmi_hit) ? pick : '0;
    assign last_done = (unit_end && xfer_last) ? owner : '0;

    assign grant      = (state == ST_XFER) ? owner : '0;
    assign bus_req    = (state == ST_XFER);
    assign xfer_start = start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            owner    <= '0;
            start_q  <= 1'b0;
            nmi_q    <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_q    <= nmi_in;
            nmi_pend <= nmi_hit & ~nmi_clr;
            case (state)
                ST_IDLE: begin
                    start_q <= 1'b0;
                    if (|accept) begin
                        owner   <= accept;
                        state   <= ST_XFER;
                        start_q <= 1'b1;
                    end
                end
                ST_XFER: begin
                    start_q <= 1'b0;
                    if (unit_end) begin
                        if (!nmi_hit && owner_blk && !xfer_last) begin
                            start_q <= 1'b1;
                        end else begin
                            state <= ST_IDLE;
                            owner <= '0;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int  NUM_CH  = DMA_NUM_CH,
    parameter int  NUM_SRC = DMA_NUM_SRC,
    localparam int SEL_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CH-1:0]  cfg_wr,
    input  logic               cfg_en,
    input  logic               cfg_tc,
    input  logic               cfg_stg,
    input  logic               cfg_blk,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [NUM_SRC-1:0] periph_irq,
    input  logic               nmi_in,
    input  logic               xfer_done,
    input  logic               xfer_last,
    output logic [NUM_CH-1:0]  grant,
    output logic               bus_req,
    output logic               xfer_start,
    output logic               nmi_ack,
    output logic [NUM_CH-1:0]  ch_en,
    output logic [NUM_CH-1:0]  ch_tc,
    output logic [NUM_CH-1:0]  ch_stg
);
    ch_ctrl_t           wr_ctrl;
    ch_ctrl_t           ch_ctrl [NUM_CH];
    logic [NUM_SRC-1:0] irq_q;
    logic [NUM_SRC-1:0] src_rise;
    logic [NUM_CH-1:0]  req_vec;
    logic [NUM_CH-1:0]  blk_vec;
    logic [NUM_CH-1:0]  accept;
    logic [NUM_CH-1:0]  last_done;
    logic               nmi_clr;
    logic               owner_blk;
    logic               nmi_hit;

    assign wr_ctrl = '{en: cfg_en, tc: cfg_tc, stg: cfg_stg, blk: cfg_blk};

    // Shared edge detector for all peripheral lines.
    always_ff @(posedge clk) begin
        if (rst) irq_q <= '0;
        else     irq_q <= periph_irq;
    end
    assign src_rise = periph_irq & ~irq_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dma_ch_ctrl #(.NUM_SRC(NUM_SRC)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .wr        (cfg_wr[c]),
            .wdata     (wr_ctrl),
            .wsel      (cfg_sel),
            .src_rise  (src_rise),
            .accept    (accept[c]),
            .last_done (last_done[c]),
            .nmi_clr   (nmi_clr),
            .ctrl      (ch_ctrl[c]),
            .req       (req_vec[c])
        );
        assign ch_en[c]   = ch_ctrl[c].en;
        assign ch_tc[c]   = ch_ctrl[c].tc;
        assign ch_stg[c]  = ch_ctrl[c].stg;
        assign blk_vec[c] = ch_ctrl[c].blk;
    end

    dma_seq #(.NUM_CH(NUM_CH)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req        (req_vec),
        .blk_mode   (blk_vec),
        .xfer_done  (xfer_done),
        .xfer_last  (xfer_last),
        .nmi_in     (nmi_in),
        .grant      (grant),
        .bus_req    (bus_req),
        .xfer_start (xfer_start),
        .accept     (accept),
        .last_done  (last_done),
        .nmi_clr    (nmi_clr),
        .owner_blk  (owner_blk),
        .nmi_hit    (nmi_hit)
    );

    assign nmi_ack = nmi_clr;

endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] cfg_wr,
    input logic [NUM_CH-1:0] grant,
    input logic              bus_req,
    input logic              xfer_start,
    input logic              xfer_done,
    input logic              xfer_last,
    input logic              nmi_ack,
    input logic [NUM_CH-1:0] ch_en,
    input logic [NUM_CH-1:0] ch_tc,
    input logic [NUM_CH-1:0] ch_stg,
    input logic [NUM_CH-1:0] req_vec,
    input logic              owner_blk,
    input logic              nmi_hit
);
    localparam logic [NUM_CH-1:0] ONE = NUM_CH'(1);

    p_grant_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    p_grant_busreq_r10: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) == bus_req);

    p_prio_lowest_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> (($past(req_vec) & (grant - ONE)) == '0));

    p_single_release_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_req && xfer_done && !owner_blk) |=> !bus_req);

    p_block_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_req && xfer_done && owner_blk && !xfer_last && !nmi_hit)
        |=> (bus_req && xfer_start && grant == $past(grant)));

    p_start_owned_r3: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> bus_req);

    p_stg_clear_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(bus_req) && $past(cfg_wr) == '0) |-> ((ch_stg & grant) == '0));

    p_tc_gate_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> (($past(ch_tc) & grant) == '0));

    p_nmi_wait_r7: assert property (@(posedge clk) disable iff (rst)
        nmi_ack |-> (!bus_req || xfer_done));

    p_nmi_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (nmi_ack && cfg_wr == '0) |=> (ch_en == '0));

endmodule

bind dma_req_arbiter dma_arb_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .grant      (grant),
    .bus_req    (bus_req),
    .xfer_start (xfer_start),
    .xfer_done  (xfer_done),
    .xfer_last  (xfer_last),
    .nmi_ack    (nmi_ack),
    .ch_en      (ch_en),
    .ch_tc      (ch_tc),
    .ch_stg     (ch_stg),
    .req_vec    (req_vec),
    .owner_blk  (owner_blk),
    .nmi_hit    (nmi_hit)
);

// File: tb/tb_dma_req_arbiter.sv
module tb_dma_req_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 4;
    localparam int NUM_SRC    = 8;
    localparam int SEL_W      = $clog2(NUM_SRC);
    localparam int WD_CYCLES  = 5000;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_CH-1:0]  cfg_wr = '0;
    logic               cfg_en = 1'b0, cfg_tc = 1'b0, cfg_stg = 1'b0, cfg_blk = 1'b0;
    logic [SEL_W-1:0]   cfg_sel = '0;
    logic [NUM_SRC-1:0] periph_irq = '0;
    logic               nmi_in = 1'b0, xfer_done = 1'b0, xfer_last = 1'b0;
    logic [NUM_CH-1:0]  grant, ch_en, ch_tc, ch_stg;
    logic               bus_req, xfer_start, nmi_ack;

    int   n_tests = 0;
    int   n_fail  = 0;
    logic ack_seen;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_req_arbiter #(.NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC)) dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_tc(cfg_tc),
        .cfg_stg(cfg_stg), .cfg_blk(cfg_blk), .cfg_sel(cfg_sel),
        .periph_irq(periph_irq), .nmi_in(nmi_in), .xfer_done(xfer_done),
        .xfer_last(xfer_last), .grant(grant), .bus_req(bus_req),
        .xfer_start(xfer_start), .nmi_ack(nmi_ack), .ch_en(ch_en),
        .ch_tc(ch_tc), .ch_stg(ch_stg)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // All helpers below are entered and left at a falling edge.
    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_ch(input logic [NUM_CH-1:0] mask, input logic en, input logic tc,
                         input logic stg, input logic blk, input logic [SEL_W-1:0] sel);
        cfg_wr = mask; cfg_en = en; cfg_tc = tc; cfg_stg = stg; cfg_blk = blk; cfg_sel = sel;
        @(negedge clk);
        cfg_wr = '0;
    endtask

    task automatic irq_pulse(input int line);
        periph_irq[line] = 1'b1;
        @(negedge clk);
        periph_irq[line] = 1'b0;
    endtask

    task automatic nmi_pulse();
        nmi_in = 1'b1;
        #1 ack_seen = nmi_ack;
        @(negedge clk);
        nmi_in = 1'b0;
    endtask

    task automatic finish_unit(input logic last);
        xfer_done = 1'b1; xfer_last = last;
        #1 ack_seen = nmi_ack;
        @(negedge clk);
        xfer_done = 1'b0; xfer_last = 1'b0;
    endtask

    task automatic idle_chk(input int n, input string tag);
        repeat (n) begin
            @(negedge clk);
            chk(tag, {31'd0, bus_req}, 32'd0);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R11 grant after reset", {28'd0, grant}, 32'd0);
        chk("R11 bus_req after reset", {31'd0, bus_req}, 32'd0);
        chk("R11 xfer_start after reset", {31'd0, xfer_start}, 32'd0);
        chk("R11 nmi_ack after reset", {31'd0, nmi_ack}, 32'd0);
        chk("R11 ctrl bits after reset", {20'd0, ch_en, ch_tc, ch_stg}, 32'd0);
    endtask

    task automatic t_priority();
        do_reset();
        wr_ch(4'b1010, 1, 0, 1, 0, 0);
        chk("R1 no grant in arbitration cycle", {31'd0, bus_req}, 32'd0);
        @(negedge clk);
        chk("R1 lower index wins", {28'd0, grant}, 32'h2);
        chk("R1 start strobe", {31'd0, xfer_start}, 32'd1);
        finish_unit(0);
        chk("R2 bus released after unit", {31'd0, bus_req}, 32'd0);
        chk("R10 grant low when released", {28'd0, grant}, 32'd0);
        @(negedge clk);
        chk("R2 next channel granted", {28'd0, grant}, 32'h8);
        finish_unit(1);
        chk("R6 tc set on last unit", {28'd0, ch_tc}, 32'h8);
        idle_chk(3, "R5 no rerun after stg consumed");
    endtask

    task automatic t_preempt();
        do_reset();
        wr_ch(4'b0001, 1, 0, 0, 0, 3'd5);
        wr_ch(4'b1000, 1, 0, 1, 0, 0);
        @(negedge clk);
        chk("R2 low channel owns bus", {28'd0, grant}, 32'h8);
        irq_pulse(5);
        chk("R2 no switch mid-unit", {28'd0, grant}, 32'h8);
        finish_unit(0);
        chk("R2 release cycle", {31'd0, bus_req}, 32'd0);
        @(negedge clk);
        chk("R2 latched higher request wins", {28'd0, grant}, 32'h1);
        finish_unit(1);
    endtask

    task automatic t_block();
        do_reset();
        wr_ch(4'b1000, 1, 0, 1, 1, 0);
        @(negedge clk);
        chk("R3 block owner granted", {28'd0, grant}, 32'h8);
        wr_ch(4'b0001, 1, 0, 1, 0, 0);
        chk("R3 owner kept while ch0 pending", {28'd0, grant}, 32'h8);
        for (int u = 0; u < 2; u++) begin
            finish_unit(0);
            chk("R3 bus held between units", {31'd0, bus_req}, 32'd1);
            chk("R3 grant locked between units", {28'd0, grant}, 32'h8);
            chk("R3 next unit started", {31'd0, xfer_start}, 32'd1);
        end
        finish_unit(1);
        chk("R3 bus released after last unit", {31'd0, bus_req}, 32'd0);
        chk("R6 tc of block channel", {31'd0, ch_tc[3]}, 32'd1);
        @(negedge clk);
        chk("R3 waiting channel then granted", {28'd0, grant}, 32'h1);
        finish_unit(1);
        chk("R6 both tc set", {28'd0, ch_tc}, 32'h9);
        idle_chk(3, "R6 tc channels not regranted");
    endtask

    task automatic t_software();
        do_reset();
        wr_ch(4'b0100, 0, 0, 1, 0, 0);
        chk("R5 stg readable", {31'd0, ch_stg[2]}, 32'd1);
        idle_chk(2, "R5 disabled channel ignores stg");
        wr_ch(4'b0100, 1, 1, 1, 0, 0);
        idle_chk(2, "R6 tc=1 channel ignores stg");
        wr_ch(4'b0100, 1, 0, 1, 0, 0);
        @(negedge clk);
        chk("R5 software start", {28'd0, grant}, 32'h4);
        chk("R5 stg self-cleared", {31'd0, ch_stg[2]}, 32'd0);
        finish_unit(0);
        idle_chk(3, "R5 single request gives one unit");
    endtask

    task automatic t_hardware();
        do_reset();
        wr_ch(4'b0010, 0, 0, 0, 0, 3'd2);
        irq_pulse(2);
        idle_chk(2, "R4 edge ignored while disabled");
        wr_ch(4'b0010, 1, 1, 0, 0, 3'd2);
        irq_pulse(2);
        idle_chk(2, "R4 edge ignored with tc=1");
        wr_ch(4'b0010, 1, 0, 0, 0, 3'd2);
        idle_chk(2, "R4 earlier edges not kept");
        irq_pulse(3);
        idle_chk(2, "R4 unselected line ignored");
        periph_irq[2] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R4 selected edge starts channel", {28'd0, grant}, 32'h2);
        finish_unit(0);
        idle_chk(3, "R4 held level gives one request");
        periph_irq[2] = 1'b0;
        @(negedge clk);
        irq_pulse(2);
        @(negedge clk);
        chk("R4 new edge restarts", {28'd0, grant}, 32'h2);
        finish_unit(1);
    endtask

    task automatic t_nmi_single();
        do_reset();
        wr_ch(4'b0001, 1, 0, 0, 0, 0);
        nmi_pulse();
        chk("R7 idle nmi acked at once", {31'd0, ack_seen}, 32'd1);
        chk("R7 idle nmi clears enables", {28'd0, ch_en}, 32'd0);
        wr_ch(4'b0100, 1, 0, 0, 0, 3'd1);
        irq_pulse(1);
        @(negedge clk);
        chk("R9 channel running", {28'd0, grant}, 32'h4);
        irq_pulse(1);
        nmi_pulse();
        chk("R7 no ack while unit in flight", {31'd0, ack_seen}, 32'd0);
        chk("R7 unit not cut short", {31'd0, bus_req}, 32'd1);
        finish_unit(0);
        chk("R7 ack at unit end", {31'd0, ack_seen}, 32'd1);
        chk("R7 all enables cleared", {28'd0, ch_en}, 32'd0);
        chk("R7 ack is a pulse", {31'd0, nmi_ack}, 32'd0);
        idle_chk(3, "R7 disabled after nmi");
        wr_ch(4'b0100, 1, 0, 0, 0, 3'd1);
        idle_chk(3, "R9 stale request discarded");
        irq_pulse(1);
        @(negedge clk);
        chk("R9 new request accepted", {28'd0, grant}, 32'h4);
        finish_unit(1);
    endtask

    task automatic t_nmi_block();
        do_reset();
        wr_ch(4'b0010, 1, 0, 1, 1, 0);
        @(negedge clk);
        chk("R8 block started", {28'd0, grant}, 32'h2);
        nmi_pulse();
        finish_unit(0);
        chk("R8 ack at unit end", {31'd0, ack_seen}, 32'd1);
        chk("R8 enable cleared", {31'd0, ch_en[1]}, 32'd0);
        chk("R8 tc still clear", {31'd0, ch_tc[1]}, 32'd0);
        idle_chk(3, "R8 block paused");
        wr_ch(4'b0010, 1, 0, 0, 1, 0);
        @(negedge clk);
        chk("R8 block resumes without trigger", {28'd0, grant}, 32'h2);
        chk("R8 resume starts unit", {31'd0, xfer_start}, 32'd1);
        finish_unit(0);
        chk("R8 resumed block keeps bus", {31'd0, xfer_start}, 32'd1);
        finish_unit(1);
        chk("R8 resumed block completes", {31'd0, ch_tc[1]}, 32'd1);
        chk("R8 bus released", {31'd0, bus_req}, 32'd0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_priority();
        t_preempt();
        t_block();
        t_software();
        t_hardware();
        t_nmi_single();
        t_nmi_block();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule